// File: doc/BRIEF.md
# PWM Diode Emulation Output Controller

This block sits between a two-channel PWM generator and its output pins. In normal operation the two PWM signals pass straight through. When diode emulation is enabled and a trip event arrives, an internal emulation flag is set. While that flag is up, each output is driven by its own selected source instead of the PWM signal: the high-side trip comparator, the low-side trip comparator, a constant 0 or a constant 1. A per-channel polarity bit can invert the selected source.

A single-cycle exit strobe clears the emulation flag. At that moment a lockout counter is loaded with a programmed re-entry delay. The counter counts down on sync-period pulses and, while it is non-zero, trip events cannot set the flag again. A separate PWM trip input, when allowed by a trip-enable bit, forces both outputs back to the raw PWM signals whatever the emulation state.

Top module: `pwm_diode_emu`

## Requirements
- R1: While the emulation flag is clear (and no PWM trip override applies), out_a equals pwm_a and out_b equals pwm_b in the same cycle.
- R2: A trip_evt sampled at a clock edge with mode_en=1, exit_strobe=0 and the lockout counter at zero sets the emulation flag (emu_active) after that edge.
- R3: exit_strobe clears emu_active at the next edge and wins over a trip_evt in the same cycle.
- R4: While emu_active is set, each output follows its own 2-bit select: 00 = trip_lo, 01 = trip_hi, 10 = constant 0, 11 = constant 1; the two channels select independently.
- R5: The polarity bit of a channel, when 1, inverts the selected source after the select; when 0 the source passes unchanged.
- R6: At the edge where exit_strobe clears a set emu_active, the lockout counter is loaded with reentry_dly; while the counter is non-zero, trip_evt does not set emu_active.
- R7: The lockout counter decrements by one only at edges where sync_pulse is 1 and the counter is above zero; after reentry_dly sync pulses a trip sets the flag again.
- R8: A reentry_dly of 0 gives no lockout: a trip in the cycle right after the exit sets emu_active.
- R9: When pwm_trip=1 and trip_en=1, out_a and out_b equal pwm_a and pwm_b even while emu_active is set; with trip_en=0, pwm_trip has no effect.
- R10: A synchronous active-low reset clears emu_active and the lockout counter, so outputs pass the PWM signals.
- R11: With mode_en=0, trip_evt does not set emu_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Diode emulation enable |
| trip_evt | input | 1 | Trip event that arms emulation |
| exit_strobe | input | 1 | Single-cycle emulation exit |
| sync_pulse | input | 1 | Sync-period pulse for the lockout counter |
| reentry_dly | input | 8 | Lockout length in sync periods |
| pwm_a | input | 1 | Incoming PWM channel A |
| pwm_b | input | 1 | Incoming PWM channel B |
| trip_hi | input | 1 | High-side trip comparator |
| trip_lo | input | 1 | Low-side trip comparator |
| sel_a | input | 2 | Channel A source select |
| sel_b | input | 2 | Channel B source select |
| pol_a | input | 1 | Channel A inversion |
| pol_b | input | 1 | Channel B inversion |
| pwm_trip | input | 1 | PWM trip from the generator |
| trip_en | input | 1 | Allows pwm_trip to override |
| out_a | output | 1 | Drive for pin A |
| out_b | output | 1 | Drive for pin B |
| emu_active | output | 1 | Emulation flag |

## Verification
The assertions take for granted that all inputs are synchronous to clk and stable around the sampling edge, and that exit_strobe is meant as a single-cycle strobe, though the flag and counter checks hold for any pulse width. The stimulus changes inputs only on the falling clock edge and keeps reentry_dly constant across each exit so that the loaded value is well defined. Lockout windows are kept short (a few sync pulses) so that both the masked and the re-armed cases are observed at the ports.

// File: rtl/dem_pkg.sv
package dem_pkg;

    typedef enum logic [1:0] {
        SRC_TRIPL = 2'b00,
        SRC_TRIPH = 2'b01,
        SRC_ZERO  = 2'b10,
        SRC_ONE   = 2'b11
    } dem_src_e;

    typedef struct packed {
        logic active;
    } dem_flag_t;

endpackage

// File: rtl/dem_lockout.sv
module dem_lockout #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             sync_i,
    output logic             locked_o
);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } lock_st_t;

    localparam logic [DLY_W-1:0] CNT_ZERO = '0;
    localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = dly_i;
        end else if (sync_i && (st_q.cnt != CNT_ZERO)) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = (st_q.cnt != CNT_ZERO);

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(dly_i)));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (st_q.cnt == CNT_ZERO)) |=> (st_q.cnt == CNT_ZERO));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !sync_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dem_chan_sel.sv
module dem_chan_sel
    import dem_pkg::*;
(
    input  logic       pwm_i,
    input  logic       trip_hi_i,
    input  logic       trip_lo_i,
    input  logic [1:0] sel_i,
    input  logic       pol_i,
    input  logic       emu_i,
    input  logic       bypass_i,
    output logic       out_o
);

    logic src;

    always_comb begin
        unique case (dem_src_e'(sel_i))
            SRC_TRIPL: src = trip_lo_i;
            SRC_TRIPH: src = trip_hi_i;
            SRC_ZERO:  src = 1'b0;
            SRC_ONE:   src = 1'b1;
            default:   src = 1'b0;
        endcase
    end

    always_comb begin
        if (bypass_i || !emu_i) begin
            out_o = pwm_i;
        end else begin
            out_o = src ^ pol_i;
        end
    end

endmodule

// File: rtl/pwm_diode_emu.sv
module pwm_diode_emu
    import dem_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             trip_evt,
    input  logic             exit_strobe,
    input  logic             sync_pulse,
    input  logic [DLY_W-1:0] reentry_dly,
    input  logic             pwm_a,
    input  logic             pwm_b,
    input  logic             trip_hi,
    input  logic             trip_lo,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic             pwm_trip,
    input  logic             trip_en,
    output logic             out_a,
    output logic             out_b,
    output logic             emu_active
);

    localparam int NCH = 2;

    dem_flag_t flag_d, flag_q;
    logic      locked;
    logic      lock_load;
    logic      bypass;

    logic [NCH-1:0]      pwm_v;
    logic [NCH-1:0]      pol_v;
    logic [NCH-1:0][1:0] sel_v;
    logic [NCH-1:0]      out_v;

    always_comb begin
        flag_d = flag_q;
        if (exit_strobe) begin
            flag_d.active = 1'b0;
        end else if (trip_evt && mode_en && !locked) begin
            flag_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign lock_load = flag_q.active && exit_strobe;
    assign bypass    = pwm_trip && trip_en;

    dem_lockout #(.DLY_W(DLY_W)) u_lockout (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (lock_load),
        .dly_i    (reentry_dly),
        .sync_i   (sync_pulse),
        .locked_o (locked)
    );

    assign pwm_v = {pwm_b, pwm_a};
    assign pol_v = {pol_b, pol_a};
    assign sel_v = {sel_b, sel_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dem_chan_sel u_sel (
            .pwm_i     (pwm_v[ch]),
            .trip_hi_i (trip_hi),
            .trip_lo_i (trip_lo),
            .sel_i     (sel_v[ch]),
            .pol_i     (pol_v[ch]),
            .emu_i     (flag_q.active),
            .bypass_i  (bypass),
            .out_o     (out_v[ch])
        );
    end

    assign out_a      = out_v[0];
    assign out_b      = out_v[1];
    assign emu_active = flag_q.active;

    assert_exit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exit_strobe |=> !emu_active);

    assert_trip_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_evt && mode_en && !exit_strobe && !locked) |=> emu_active);

    assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_active && locked) |=> !emu_active);

    assert_mode_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_active && !mode_en) |=> !emu_active);

    assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_active |-> (out_a == pwm_a && out_b == pwm_b));

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_trip && trip_en) |-> (out_a == pwm_a && out_b == pwm_b));

endmodule

// File: tb/pwm_diode_emu_tb.sv
module pwm_diode_emu_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_en, trip_evt, exit_strobe, sync_pulse;
    logic [7:0] reentry_dly;
    logic       pwm_a, pwm_b, trip_hi, trip_lo;
    logic [1:0] sel_a, sel_b;
    logic       pol_a, pol_b, pwm_trip, trip_en;
    logic       out_a, out_b, emu_active;

    always #2 clk = ~clk;

    pwm_diode_emu u_dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .trip_evt(trip_evt),
        .exit_strobe(exit_strobe), .sync_pulse(sync_pulse),
        .reentry_dly(reentry_dly), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .trip_hi(trip_hi), .trip_lo(trip_lo), .sel_a(sel_a), .sel_b(sel_b),
        .pol_a(pol_a), .pol_b(pol_b), .pwm_trip(pwm_trip), .trip_en(trip_en),
        .out_a(out_a), .out_b(out_b), .emu_active(emu_active)
    );

    typedef struct {
        logic [2:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event smp_ev;
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic       m_act = 1'b0;
    logic [7:0] m_cnt = 8'd0;

    function automatic logic pick(logic [1:0] s, logic p);
        logic v;
        case (s)
            2'b00:   v = trip_lo;
            2'b01:   v = trip_hi;
            2'b10:   v = 1'b0;
            default: v = 1'b1;
        endcase
        return v ^ p;
    endfunction

    task automatic tick(input string tag);
        logic       nact;
        logic [7:0] ncnt;
        exp_t       e;
        @(posedge clk);
        if (!rst_n) begin
            nact = 1'b0;
            ncnt = 8'd0;
        end else begin
            if (exit_strobe) nact = 1'b0;
            else if (trip_evt && mode_en && m_cnt == 8'd0) nact = 1'b1;
            else nact = m_act;
            if (m_act && exit_strobe) ncnt = reentry_dly;
            else if (sync_pulse && m_cnt != 8'd0) ncnt = m_cnt - 8'd1;
            else ncnt = m_cnt;
        end
        m_act = nact;
        m_cnt = ncnt;
        if ((pwm_trip && trip_en) || !m_act)
            e.val = {pwm_a, pwm_b, m_act};
        else
            e.val = {pick(sel_a, pol_a), pick(sel_b, pol_b), m_act};
        e.tag = tag;
        exp_q.push_back(e);
        #1 -> smp_ev;
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            @(smp_ev);
            e = exp_q.pop_front();
            n_cmp++;
            if ({out_a, out_b, emu_active} !== e.val) begin
                n_fail++;
                $display("FAIL %s: {a,b,active} actual=%b expected=%b",
                         e.tag, {out_a, out_b, emu_active}, e.val);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 0; mode_en = 0; trip_evt = 0; exit_strobe = 0; sync_pulse = 0;
        reentry_dly = 8'd3; pwm_a = 1; pwm_b = 0; trip_hi = 0; trip_lo = 1;
        sel_a = 2'b00; sel_b = 2'b01; pol_a = 0; pol_b = 0; pwm_trip = 0; trip_en = 0;
        @(negedge clk);
        // R10: reset state, pass-through
        tick("R10"); tick("R10");
        rst_n = 1;
        // R1: pass-through under several patterns
        for (int i = 0; i < 4; i++) begin
            {pwm_a, pwm_b} = i[1:0];
            tick("R1");
        end
        // R11: mode disabled, trip ignored
        trip_evt = 1; tick("R11"); tick("R11");
        trip_evt = 0;
        // R2: trip arms emulation
        mode_en = 1; trip_evt = 1; tick("R2");
        trip_evt = 0; tick("R2");
        // R4/R5: every select and polarity per channel, independent
        for (int s = 0; s < 16; s++) begin
            sel_a = s[1:0]; sel_b = s[3:2];
            for (int t = 0; t < 4; t++) begin
                {trip_hi, trip_lo} = t[1:0];
                pol_a = t[0]; pol_b = ~t[1];
                tick(t == 0 ? "R4" : "R5");
            end
        end
        pol_a = 0; pol_b = 0; sel_a = 2'b10; sel_b = 2'b11;
        // R9: PWM trip override and its enable
        pwm_a = 1; pwm_b = 0; pwm_trip = 1; trip_en = 0; tick("R9");
        trip_en = 1; tick("R9");
        pwm_a = 0; pwm_b = 1; tick("R9");
        pwm_trip = 0; trip_en = 0; tick("R9");
        // R3: exit wins over simultaneous trip; lockout loads 3
        reentry_dly = 8'd3; exit_strobe = 1; trip_evt = 1; tick("R3");
        exit_strobe = 0;
        // R6: trips masked while counter non-zero, no sync yet
        tick("R6"); tick("R6"); tick("R6");
        // R7: count down with sync pulses, trip held
        sync_pulse = 1; tick("R7");
        sync_pulse = 0; tick("R7");
        sync_pulse = 1; tick("R7"); tick("R7");
        sync_pulse = 0; tick("R7"); tick("R7");
        trip_evt = 0;
        // R7: extra sync pulses at zero do not wrap
        exit_strobe = 1; reentry_dly = 8'd1; tick("R7");
        exit_strobe = 0; sync_pulse = 1; tick("R7"); tick("R7");
        sync_pulse = 0; trip_evt = 1; tick("R7");
        trip_evt = 0;
        // R8: zero delay, immediate re-entry
        reentry_dly = 8'd0; exit_strobe = 1; tick("R8");
        exit_strobe = 0; trip_evt = 1; tick("R8");
        trip_evt = 0; tick("R8");
        // R10: reset mid-run clears flag and counter
        reentry_dly = 8'd5; exit_strobe = 1; tick("R10");
        exit_strobe = 0; rst_n = 0; tick("R10");
        rst_n = 1; trip_evt = 1; tick("R10");
        trip_evt = 0; tick("R10");
        done = 1;
        #1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule